// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block turns the operands of a single-register load or store into the address sent to memory and the value the base register should hold after the access. It handles five addressing modes: plain register-indirect, pre-indexed with and without base update, post-indexed with base update, and program-counter-relative. In every mode an immediate offset is either added to or subtracted from the base.

The same block also prepares the memory side of the access. For stores it drives per-byte write enables. For loads it takes the 32-bit word read from memory and returns either the whole word or one zero-extended byte. A word access to an address that is not a multiple of four raises a fault flag, and the base update is then withheld.

Every output is a combinational function of the current inputs. The block sits between the instruction decoder and the register file or memory port, in a single cycle.

Top module: `agu_ls`

## Requirements
- R1: Mode code 0 (register-indirect): `addr_o` equals `base_i`, `wb_en_o` is 0 and `wb_val_o` equals `base_i`. In every mode without base update, `wb_val_o` equals `base_i`.
- R2: Mode code 1 (pre-indexed, no update): `addr_o` is base combined with the offset, and `wb_en_o` is 0.
- R3: Mode code 2 (pre-indexed with update): `addr_o` and `wb_val_o` both equal base combined with the offset, and `wb_en_o` is 1.
- R4: Mode code 3 (post-indexed): `addr_o` equals the unmodified base, `wb_val_o` equals base combined with the offset, and `wb_en_o` is 1.
- R5: Mode code 4 (PC-relative): `addr_o` equals `pc_i` + 8 combined with the offset, and `wb_en_o` is 0.
- R6: The offset is the 12-bit unsigned `off_mag_i`. It is added when `off_neg_i` is 0 and subtracted when `off_neg_i` is 1, and all arithmetic wraps modulo 2^32.
- R7: For a load with `byte_i`=1, `ld_data_o` is byte lane `addr_o[1:0]` of `rdata_i`, zero-extended. Lane n is bits [8n+7:8n]. For a word load, `ld_data_o` equals `rdata_i`.
- R8: `lane_en_o` is 4'b1111 for a word store. For a byte store, only bit `addr_o[1:0]` is set. For any load it is 4'b0000.
- R9: A word access (`byte_i`=0) with `addr_o[1:0]` not zero sets `fault_o` and forces `wb_en_o` to 0. A byte access never faults.
- R10: Mode codes 5, 6 and 7 behave as register-indirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_i | input | 32 | Base register value |
| pc_i | input | 32 | Current program counter |
| off_mag_i | input | 12 | Unsigned immediate offset |
| off_neg_i | input | 1 | 1 = subtract offset |
| mode_i | input | 3 | Addressing mode code |
| byte_i | input | 1 | 1 = byte transfer, 0 = word |
| store_i | input | 1 | 1 = store, 0 = load |
| rdata_i | input | 32 | Word read from memory |
| addr_o | output | 32 | Transfer address |
| wb_en_o | output | 1 | Base register update enable |
| wb_val_o | output | 32 | New base register value |
| lane_en_o | output | 4 | Byte write enables |
| ld_data_o | output | 32 | Aligned load data |
| fault_o | output | 1 | Misaligned word access |

## Verification
The four base modes are driven with the same base and offset. This separates which of the two results, the address or the update value, carries the offset, and whether the update is enabled. The subtract cases, wrap-around cases at both ends of the address space and the largest offset show that the offset is applied with its sign and at its full width. The PC-relative cases use a known target, which exposes a missing or wrong bias of 8. Byte loads and byte stores visit all four lanes, and word accesses are tried both aligned and misaligned, so lane order and fault masking of the update can each be told apart.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int unsigned AW = 32;
    localparam int unsigned OW = 12;
    localparam int unsigned LANES = AW / 8;

    typedef enum logic [2:0] {
        AM_INDIRECT = 3'd0,
        AM_PRE      = 3'd1,
        AM_PRE_WB   = 3'd2,
        AM_POST     = 3'd3,
        AM_PCREL    = 3'd4
    } am_mode_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          wb_en;
        logic [AW-1:0] wb_val;
    } agu_res_t;
endpackage

// File: rtl/agu_offset_add.sv
module agu_offset_add #(
    parameter int unsigned AW = 32,
    parameter int unsigned OW = 12
) (
    input  logic [AW-1:0] a_i,
    input  logic [OW-1:0] mag_i,
    input  logic          neg_i,
    output logic [AW-1:0] sum_o
);
    logic [AW-1:0] mag_ext;

    always_comb begin
        mag_ext = {{(AW-OW){1'b0}}, mag_i};
        sum_o   = neg_i ? (a_i - mag_ext) : (a_i + mag_ext);
    end
endmodule

// File: rtl/agu_lane_ctrl.sv
module agu_lane_ctrl #(
    parameter int unsigned LANES = 4,
    localparam int unsigned SW = $clog2(LANES)
) (
    input  logic [SW-1:0]    sel_i,
    input  logic             byte_i,
    input  logic             store_i,
    output logic [LANES-1:0] lane_en_o,
    output logic             fault_o
);
    always_comb begin
        lane_en_o = '0;
        if (store_i) begin
            if (byte_i) lane_en_o[sel_i] = 1'b1;
            else        lane_en_o = '1;
        end
        fault_o = !byte_i && (sel_i != '0);
    end

    always_comb begin
        if (!$isunknown({sel_i, byte_i, store_i})) begin
            a_r8_lane_count: assert ($countones(lane_en_o) == 0 || $countones(lane_en_o) == 1
                                     || $countones(lane_en_o) == LANES)
                else $error("lane enable count illegal");
            a_r9_byte_no_fault: assert (!(byte_i && fault_o))
                else $error("byte access faulted");
        end
    end
endmodule

// File: rtl/agu_load_extract.sv
module agu_load_extract #(
    parameter int unsigned LANES = 4,
    localparam int unsigned DW = LANES * 8,
    localparam int unsigned SW = $clog2(LANES)
) (
    input  logic [DW-1:0] rdata_i,
    input  logic [SW-1:0] sel_i,
    input  logic          byte_i,
    output logic [DW-1:0] data_o
);
    logic [7:0] lane_b [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_b[g] = rdata_i[8*g +: 8];
    end

    always_comb begin
        if (byte_i) data_o = {{(DW-8){1'b0}}, lane_b[sel_i]};
        else        data_o = rdata_i;
    end

    always_comb begin
        if (!$isunknown({byte_i, data_o})) begin
            a_r7_byte_zext: assert (!byte_i || data_o[DW-1:8] == '0)
                else $error("byte load not zero-extended");
        end
    end
endmodule

// File: rtl/agu_ls.sv
module agu_ls
    import agu_pkg::*;
#(
    parameter int unsigned PC_BIAS = 8
) (
    input  logic [31:0] base_i,
    input  logic [31:0] pc_i,
    input  logic [11:0] off_mag_i,
    input  logic        off_neg_i,
    input  logic [2:0]  mode_i,
    input  logic        byte_i,
    input  logic        store_i,
    input  logic [31:0] rdata_i,
    output logic [31:0] addr_o,
    output logic        wb_en_o,
    output logic [31:0] wb_val_o,
    output logic [3:0]  lane_en_o,
    output logic [31:0] ld_data_o,
    output logic        fault_o
);
    localparam int unsigned SW = $clog2(LANES);

    logic [AW-1:0] base_sum;
    logic [AW-1:0] pc_biased;
    logic [AW-1:0] pc_sum;
    agu_res_t      res_d;
    logic          fault_d;

    assign pc_biased = pc_i + AW'(PC_BIAS);

    agu_offset_add #(.AW(AW), .OW(OW)) u_base_add (
        .a_i(base_i), .mag_i(off_mag_i), .neg_i(off_neg_i), .sum_o(base_sum)
    );

    agu_offset_add #(.AW(AW), .OW(OW)) u_pc_add (
        .a_i(pc_biased), .mag_i(off_mag_i), .neg_i(off_neg_i), .sum_o(pc_sum)
    );

    always_comb begin
        res_d.addr   = base_i;
        res_d.wb_en  = 1'b0;
        res_d.wb_val = base_i;
        case (mode_i)
            AM_PRE:    res_d.addr = base_sum;
            AM_PRE_WB: begin
                res_d.addr   = base_sum;
                res_d.wb_en  = 1'b1;
                res_d.wb_val = base_sum;
            end
            AM_POST: begin
                res_d.wb_en  = 1'b1;
                res_d.wb_val = base_sum;
            end
            AM_PCREL:  res_d.addr = pc_sum;
            default:   ;
        endcase
    end

    agu_lane_ctrl #(.LANES(LANES)) u_lanes (
        .sel_i(res_d.addr[SW-1:0]), .byte_i(byte_i), .store_i(store_i),
        .lane_en_o(lane_en_o), .fault_o(fault_d)
    );

    agu_load_extract #(.LANES(LANES)) u_extract (
        .rdata_i(rdata_i), .sel_i(res_d.addr[SW-1:0]), .byte_i(byte_i),
        .data_o(ld_data_o)
    );

    assign addr_o   = res_d.addr;
    assign wb_val_o = res_d.wb_val;
    assign wb_en_o  = res_d.wb_en && !fault_d;
    assign fault_o  = fault_d;

    always_comb begin
        if (!$isunknown({base_i, mode_i, addr_o, wb_en_o, wb_val_o, fault_o})) begin
            a_r9_fault_blocks_wb: assert (!(fault_o && wb_en_o))
                else $error("update enabled on faulting access");
            a_r4_post_uses_base: assert (mode_i != AM_POST || addr_o == base_i)
                else $error("post-index address not base");
            a_r1_no_wb_keeps_base: assert (wb_en_o || fault_o || wb_val_o == base_i)
                else $error("base value changed without update");
            a_r3_pre_wb_match: assert (mode_i != AM_PRE_WB || wb_val_o == addr_o)
                else $error("pre-index update differs from address");
        end
    end
endmodule

// File: tb/agu_ls_tb.sv
module agu_ls_tb;
    logic        clk = 1'b0;
    logic [31:0] base_i = '0, pc_i = '0, rdata_i = '0;
    logic [11:0] off_mag_i = '0;
    logic        off_neg_i = 1'b0, byte_i = 1'b0, store_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [31:0] addr_o, wb_val_o, ld_data_o;
    logic        wb_en_o, fault_o;
    logic [3:0]  lane_en_o;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    agu_ls u_dut (
        .base_i(base_i), .pc_i(pc_i), .off_mag_i(off_mag_i), .off_neg_i(off_neg_i),
        .mode_i(mode_i), .byte_i(byte_i), .store_i(store_i), .rdata_i(rdata_i),
        .addr_o(addr_o), .wb_en_o(wb_en_o), .wb_val_o(wb_val_o),
        .lane_en_o(lane_en_o), .ld_data_o(ld_data_o), .fault_o(fault_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] m, input logic [31:0] b, input logic [11:0] o,
                         input logic neg, input logic byt, input logic st);
        @(posedge clk);
        mode_i = m; base_i = b; off_mag_i = o; off_neg_i = neg;
        byte_i = byt; store_i = st;
        @(negedge clk);
    endtask

    task automatic t_idle();
        @(negedge clk);
        chk("R1", "idle addr", addr_o, 32'h0);
        chk("R1", "idle wb_en", {31'b0, wb_en_o}, 32'h0);
        chk("R8", "idle lanes", {28'b0, lane_en_o}, 32'h0);
        chk("R9", "idle fault", {31'b0, fault_o}, 32'h0);
    endtask

    task automatic t_modes();
        drive(3'd0, 32'h0002_0000, 12'd4, 1'b0, 1'b0, 1'b0);
        chk("R1", "ind addr", addr_o, 32'h0002_0000);
        chk("R1", "ind wb_en", {31'b0, wb_en_o}, 32'h0);
        chk("R1", "ind wb_val", wb_val_o, 32'h0002_0000);
        drive(3'd1, 32'h0002_0000, 12'd4, 1'b0, 1'b0, 1'b0);
        chk("R2", "pre addr", addr_o, 32'h0002_0004);
        chk("R2", "pre wb_en", {31'b0, wb_en_o}, 32'h0);
        chk("R1", "pre wb_val", wb_val_o, 32'h0002_0000);
        drive(3'd2, 32'h0002_0000, 12'd4, 1'b0, 1'b0, 1'b0);
        chk("R3", "prewb addr", addr_o, 32'h0002_0004);
        chk("R3", "prewb wb_en", {31'b0, wb_en_o}, 32'h1);
        chk("R3", "prewb wb_val", wb_val_o, 32'h0002_0004);
        drive(3'd3, 32'h0002_0000, 12'd4, 1'b0, 1'b0, 1'b0);
        chk("R4", "post addr", addr_o, 32'h0002_0000);
        chk("R4", "post wb_en", {31'b0, wb_en_o}, 32'h1);
        chk("R4", "post wb_val", wb_val_o, 32'h0002_0004);
    endtask

    task automatic t_offset();
        drive(3'd2, 32'h0004_0010, 12'h010, 1'b1, 1'b0, 1'b0);
        chk("R6", "sub addr", addr_o, 32'h0004_0000);
        drive(3'd1, 32'hFFFF_FFFC, 12'd8, 1'b0, 1'b0, 1'b0);
        chk("R6", "wrap up addr", addr_o, 32'h0000_0004);
        drive(3'd3, 32'h0000_0000, 12'd4, 1'b1, 1'b0, 1'b0);
        chk("R6", "wrap down wb_val", wb_val_o, 32'hFFFF_FFFC);
        drive(3'd1, 32'h0000_1000, 12'hFFF, 1'b0, 1'b1, 1'b0);
        chk("R6", "max offset addr", addr_o, 32'h0000_1FFF);
    endtask

    task automatic t_pcrel();
        pc_i = 32'h0000_8FE4;
        drive(3'd4, 32'h1234_5678, 12'd4, 1'b0, 1'b0, 1'b0);
        chk("R5", "pcrel addr", addr_o, 32'h0000_8FF0);
        chk("R5", "pcrel wb_en", {31'b0, wb_en_o}, 32'h0);
        pc_i = 32'h0000_0100;
        drive(3'd4, 32'h0, 12'h010, 1'b1, 1'b0, 1'b0);
        chk("R5", "pcrel sub addr", addr_o, 32'h0000_00F8);
        pc_i = 32'h0;
    endtask

    task automatic t_spare_modes();
        for (int m = 5; m < 8; m++) begin
            drive(3'(m), 32'h0003_0000, 12'd8, 1'b0, 1'b0, 1'b0);
            chk("R10", "spare addr", addr_o, 32'h0003_0000);
            chk("R10", "spare wb_en", {31'b0, wb_en_o}, 32'h0);
        end
    endtask

    task automatic t_loads();
        logic [31:0] exp_b [4] = '{32'h12, 32'hD2, 32'hB2, 32'hA4};
        rdata_i = 32'hA4B2_D212;
        for (int l = 0; l < 4; l++) begin
            drive(3'd1, 32'h0001_0000, 12'(l), 1'b0, 1'b1, 1'b0);
            chk("R7", "byte load", ld_data_o, exp_b[l]);
            chk("R8", "load lanes", {28'b0, lane_en_o}, 32'h0);
        end
        drive(3'd0, 32'h0001_0000, 12'd0, 1'b0, 1'b0, 1'b0);
        chk("R7", "word load", ld_data_o, 32'hA4B2_D212);
    endtask

    task automatic t_stores();
        for (int l = 0; l < 4; l++) begin
            drive(3'd3, 32'h0005_0000 + 32'(l), 12'd1, 1'b0, 1'b1, 1'b1);
            chk("R8", "byte store lanes", {28'b0, lane_en_o}, 32'(1 << l));
        end
        drive(3'd2, 32'h0005_0000, 12'd4, 1'b0, 1'b0, 1'b1);
        chk("R8", "word store lanes", {28'b0, lane_en_o}, 32'hF);
    endtask

    task automatic t_align();
        drive(3'd2, 32'h0002_0001, 12'd0, 1'b0, 1'b0, 1'b0);
        chk("R9", "mis fault", {31'b0, fault_o}, 32'h1);
        chk("R9", "mis wb_en", {31'b0, wb_en_o}, 32'h0);
        drive(3'd2, 32'h0002_0001, 12'd0, 1'b0, 1'b1, 1'b0);
        chk("R9", "byte no fault", {31'b0, fault_o}, 32'h0);
        chk("R9", "byte wb_en", {31'b0, wb_en_o}, 32'h1);
        drive(3'd3, 32'h0002_0002, 12'd2, 1'b0, 1'b0, 1'b1);
        chk("R9", "post mis fault", {31'b0, fault_o}, 32'h1);
        chk("R9", "post mis wb_en", {31'b0, wb_en_o}, 32'h0);
        drive(3'd1, 32'h0002_0000, 12'd2, 1'b0, 1'b0, 1'b0);
        chk("R9", "offset mis fault", {31'b0, fault_o}, 32'h1);
        drive(3'd1, 32'h0002_0000, 12'd8, 1'b0, 1'b0, 1'b0);
        chk("R9", "aligned no fault", {31'b0, fault_o}, 32'h0);
    endtask

    initial begin
        t_idle();
        t_modes();
        t_offset();
        t_pcrel();
        t_spare_modes();
        t_loads();
        t_stores();
        t_align();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule